// File: doc/BRIEF.md
# Time-Shared Chien Root Search and Polynomial Evaluator

This block scans every symbol position of a shortened Reed-Solomon code over GF(256) and, at each position i, evaluates three quantities at the point α^-i: the full locator polynomial, the part of the locator made only of its odd-power terms, and the evaluator polynomial. A position is flagged as a root when the locator evaluates to zero. Downstream logic divides the evaluator value by the odd-part value to form the error magnitude; that division and the correction are not part of this block.

The block runs on a clock at twice the symbol rate. One bank of GF(256) multipliers and one XOR summation tree serve both polynomials: on the even fast phase they work on the locator bank and on the odd phase on the evaluator bank. The three results of a position are registered together and held for a full symbol period (two fast cycles), so the output stream moves at the symbol rate. Positions are produced in arrival order, from index n-1 down to 0. Because the code is shortened, the registers cannot start from the raw coefficients; during a one-symbol-period preload the shared multipliers scale coefficient j by α^(-j·(n-1)), and during the scan each register j is multiplied by α^j once per position.

The controller has four states. ST_IDLE waits; the transition accept (start seen in ST_IDLE) enters ST_PRELOAD. ST_PRELOAD scales the locator on phase 0 and the evaluator on phase 1, then takes the transition preload_done into ST_SCAN. ST_SCAN evaluates one position per phase pair; after position 0 the transition scan_done enters ST_DRAIN, which lasts one symbol period and takes the transition drain_done back to ST_IDLE, raising the finished flag.

Top module: `chien_eval`

## Requirements
- R1: After reset, eval_vld, done, root_flag and root_count are 0, and pos_idx and all three value outputs are 0.
- R2: When start is high at a rising edge in the idle state, eval_vld is still 0 after the third following rising edge and is 1 after the fourth; from then each result holds for exactly two fast cycles and eval_vld stays 1 for 2·N_POS fast cycles.
- R3: pos_idx takes the values N_POS-1, N_POS-2, ..., 0, one per result, in that order.
- R4: sig_val equals Σ σj·α^(-j·i) over GF(256) with field polynomial x^8+x^4+x^3+x^2+1 (0x11D) and α = 0x02, where i = pos_idx and σj is sig_coef[8j+7:8j].
- R5: sig_odd_val equals the same sum taken over odd j only.
- R6: omg_val equals Σ ωj·α^(-j·i), with ωj taken from omg_coef[8j+7:8j].
- R7: root_flag is 1 exactly when sig_val is 0 for the position on the outputs.
- R8: done rises at the same edge at which eval_vld falls (two fast cycles after the last result first appears), stays 1 until the next accepted start clears it, and root_count then equals the number of positions flagged in the scan (up to N_POS when the locator is all zero).
- R9: start while a scan is preloading, scanning or draining has no effect on the results or their timing.
- R10: The coefficient inputs are sampled only in the two fast cycles after start is accepted; changes after that do not affect the results.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Double-rate clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Begin a scan when idle |
| sig_coef | input | 8·NSIG | Locator coefficients, byte j is σj |
| omg_coef | input | 8·NOMG | Evaluator coefficients, byte j is ωj |
| eval_vld | output | 1 | Result outputs carry a position |
| pos_idx | output | clog2(N_POS) | Symbol position of the current result |
| sig_val | output | 8 | Locator value at α^-i |
| sig_odd_val | output | 8 | Odd-term locator value at α^-i |
| omg_val | output | 8 | Evaluator value at α^-i |
| root_flag | output | 1 | Locator value is zero |
| done | output | 1 | Last scan finished |
| root_count | output | clog2(N_POS+1) | Roots found in the last scan |

## Verification
A register bank that is mis-scaled at preload shows as a wrong sig_val or omg_val on the very first result, at position N_POS-1, which only a shortened-code offset exposes; a wrong step constant appears from the second result onward and grows with the lane index, so full-degree polynomials are needed to reach every lane. A phase swap between the banks shows at once as locator and evaluator values exchanged, and a position counter off by one shifts every root flag and corrupts root_count at done. Scans with roots placed at the first and last positions and an all-zero locator catch boundary slips in the count and in the done timing within one symbol period.

// File: rtl/chien_pkg.sv
package chien_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_PRELOAD,
        ST_SCAN,
        ST_DRAIN
    } chien_state_e;

    // Low byte of the field polynomial x^8+x^4+x^3+x^2+1
    localparam logic [7:0] FIELD_LOW = 8'h1D;

    function automatic logic [7:0] gf_xtime(input logic [7:0] v);
        return {v[6:0], 1'b0} ^ (v[7] ? FIELD_LOW : 8'h00);
    endfunction

    function automatic logic [7:0] gf_mul(input logic [7:0] a, input logic [7:0] b);
        logic [7:0] acc;
        logic [7:0] sh;
        acc = 8'h00;
        sh  = a;
        for (int k = 0; k < 8; k++) begin
            if (b[k]) acc = acc ^ sh;
            sh = gf_xtime(sh);
        end
        return acc;
    endfunction

    // alpha raised to e, alpha = 0x02
    function automatic logic [7:0] gf_alpha_pow(input int unsigned e);
        logic [7:0] v;
        v = 8'h01;
        for (int unsigned k = 0; k < (e % 255); k++) v = gf_xtime(v);
        return v;
    endfunction

endpackage

// File: rtl/chien_lane.sv
// One shared multiplier lane: picks the bank by phase and the operand pair
// by mode (offset preload or per-position step).
module chien_lane #(
    parameter logic [7:0] STEP_C = 8'h01,
    parameter logic [7:0] LOAD_C = 8'h01
) (
    input  logic       load_sel,
    input  logic       bank_sel,
    input  logic [7:0] raw_sig,
    input  logic [7:0] raw_omg,
    input  logic [7:0] reg_sig,
    input  logic [7:0] reg_omg,
    output logic [7:0] prod
);
    logic [7:0] op_a;
    logic [7:0] op_b;

    always_comb begin
        if (load_sel) op_a = bank_sel ? raw_omg : raw_sig;
        else          op_a = bank_sel ? reg_omg : reg_sig;
        op_b = load_sel ? LOAD_C : STEP_C;
        prod = chien_pkg::gf_mul(op_a, op_b);
    end
endmodule

// File: rtl/chien_xor_tree.sv
// Summation over GF(256) with the odd-indexed terms tapped separately.
module chien_xor_tree #(
    parameter int NL = 9
) (
    input  logic [7:0] terms [NL],
    output logic [7:0] sum_all,
    output logic [7:0] sum_odd
);
    always_comb begin
        sum_all = 8'h00;
        sum_odd = 8'h00;
        for (int j = 0; j < NL; j++) begin
            sum_all = sum_all ^ terms[j];
            if (j % 2 == 1) sum_odd = sum_odd ^ terms[j];
        end
    end
endmodule

// File: rtl/chien_fsm.sv
module chien_fsm #(
    parameter int N_POS = 85,
    localparam int IW = $clog2(N_POS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    output logic          ph,
    output logic [IW-1:0] pos_cnt,
    output logic          accept,
    output logic          load_sel,
    output logic          we_sig,
    output logic          we_omg,
    output logic          emit,
    output logic          finish
);
    import chien_pkg::*;

    chien_state_e st;
    chien_state_e st_nx;
    logic         last_pos;

    assign last_pos = (pos_cnt == IW'(N_POS - 1));

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= st_nx;
    end

    // transitions: accept, preload_done, scan_done, drain_done
    always_comb begin
        st_nx = st;
        unique case (st)
            ST_IDLE:    if (start)           st_nx = ST_PRELOAD;
            ST_PRELOAD: if (ph)              st_nx = ST_SCAN;
            ST_SCAN:    if (ph && last_pos)  st_nx = ST_DRAIN;
            ST_DRAIN:   if (ph)              st_nx = ST_IDLE;
            default:                         st_nx = ST_IDLE;
        endcase
    end

    // phase and position counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph      <= 1'b0;
            pos_cnt <= '0;
        end else begin
            ph <= (st == ST_IDLE) ? 1'b0 : ~ph;
            if (st == ST_PRELOAD)
                pos_cnt <= '0;
            else if (st == ST_SCAN && ph && !last_pos)
                pos_cnt <= pos_cnt + IW'(1);
        end
    end

    // decoded controls
    always_comb begin
        accept   = 1'b0;
        load_sel = 1'b0;
        we_sig   = 1'b0;
        we_omg   = 1'b0;
        emit     = 1'b0;
        finish   = 1'b0;
        unique case (st)
            ST_IDLE:    accept = start;
            ST_PRELOAD: begin
                load_sel = 1'b1;
                we_sig   = !ph;
                we_omg   = ph;
            end
            ST_SCAN: begin
                we_sig = !ph;
                we_omg = ph;
                emit   = ph;
            end
            ST_DRAIN:   finish = ph;
            default: ;
        endcase
    end

    // R9: a busy scan never re-enters preload
    p_busy_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_SCAN) |=> (st != ST_PRELOAD));

    // R2: outside idle the two phases alternate every fast cycle
    p_phase_alt_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (st != ST_IDLE) |=> (ph != $past(ph)));

    // R3: counter never passes the last position
    p_cnt_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        pos_cnt <= IW'(N_POS - 1));
endmodule

// File: rtl/chien_eval.sv
module chien_eval #(
    parameter int N_POS = 85,
    parameter int NSIG  = 9,
    parameter int NOMG  = 8,
    localparam int NLANE = (NSIG > NOMG) ? NSIG : NOMG,
    localparam int IW    = $clog2(N_POS),
    localparam int CW    = $clog2(N_POS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [NSIG*8-1:0] sig_coef,
    input  logic [NOMG*8-1:0] omg_coef,
    output logic              eval_vld,
    output logic [IW-1:0]     pos_idx,
    output logic [7:0]        sig_val,
    output logic [7:0]        sig_odd_val,
    output logic [7:0]        omg_val,
    output logic              root_flag,
    output logic              done,
    output logic [CW-1:0]     root_count
);
    logic          ph;
    logic [IW-1:0] pos_cnt;
    logic          accept, load_sel, we_sig, we_omg, emit, finish;

    logic [7:0] sig_q   [NSIG];
    logic [7:0] omg_q   [NOMG];
    logic [7:0] l_raw_s [NLANE];
    logic [7:0] l_raw_o [NLANE];
    logic [7:0] l_reg_s [NLANE];
    logic [7:0] l_reg_o [NLANE];
    logic [7:0] l_prod  [NLANE];
    logic [7:0] t_in    [NLANE];
    logic [7:0] t_all, t_odd;
    logic [7:0] sig_hold, odd_hold;

    chien_fsm #(.N_POS(N_POS)) u_fsm (
        .clk(clk), .rst_n(rst_n), .start(start),
        .ph(ph), .pos_cnt(pos_cnt),
        .accept(accept), .load_sel(load_sel),
        .we_sig(we_sig), .we_omg(we_omg),
        .emit(emit), .finish(finish)
    );

    for (genvar j = 0; j < NLANE; j++) begin : g_lane
        localparam logic [7:0] STEP_J = chien_pkg::gf_alpha_pow(j);
        localparam logic [7:0] LOAD_J =
            chien_pkg::gf_alpha_pow((255 - ((j * (N_POS - 1)) % 255)) % 255);

        if (j < NSIG) begin : g_s
            assign l_raw_s[j] = sig_coef[8*j +: 8];
            assign l_reg_s[j] = sig_q[j];
        end else begin : g_s0
            assign l_raw_s[j] = 8'h00;
            assign l_reg_s[j] = 8'h00;
        end
        if (j < NOMG) begin : g_o
            assign l_raw_o[j] = omg_coef[8*j +: 8];
            assign l_reg_o[j] = omg_q[j];
        end else begin : g_o0
            assign l_raw_o[j] = 8'h00;
            assign l_reg_o[j] = 8'h00;
        end

        assign t_in[j] = ph ? l_reg_o[j] : l_reg_s[j];

        chien_lane #(.STEP_C(STEP_J), .LOAD_C(LOAD_J)) u_lane (
            .load_sel(load_sel), .bank_sel(ph),
            .raw_sig(l_raw_s[j]), .raw_omg(l_raw_o[j]),
            .reg_sig(l_reg_s[j]), .reg_omg(l_reg_o[j]),
            .prod(l_prod[j])
        );
    end

    chien_xor_tree #(.NL(NLANE)) u_tree (
        .terms(t_in), .sum_all(t_all), .sum_odd(t_odd)
    );

    // coefficient banks, written on alternate phases
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int j = 0; j < NSIG; j++) sig_q[j] <= 8'h00;
            for (int j = 0; j < NOMG; j++) omg_q[j] <= 8'h00;
        end else begin
            if (we_sig) for (int j = 0; j < NSIG; j++) sig_q[j] <= l_prod[j];
            if (we_omg) for (int j = 0; j < NOMG; j++) omg_q[j] <= l_prod[j];
        end
    end

    // even-phase locator results, held for the output update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sig_hold <= 8'h00;
            odd_hold <= 8'h00;
        end else if (we_sig && !load_sel) begin
            sig_hold <= t_all;
            odd_hold <= t_odd;
        end
    end

    // base-rate output stage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            eval_vld    <= 1'b0;
            pos_idx     <= '0;
            sig_val     <= 8'h00;
            sig_odd_val <= 8'h00;
            omg_val     <= 8'h00;
            root_flag   <= 1'b0;
            done        <= 1'b0;
            root_count  <= '0;
        end else begin
            if (accept) begin
                done       <= 1'b0;
                root_count <= '0;
            end
            if (emit) begin
                eval_vld    <= 1'b1;
                pos_idx     <= IW'(N_POS - 1) - pos_cnt;
                sig_val     <= sig_hold;
                sig_odd_val <= odd_hold;
                omg_val     <= t_all;
                root_flag   <= (sig_hold == 8'h00);
                if (sig_hold == 8'h00) root_count <= root_count + CW'(1);
            end
            if (finish) begin
                eval_vld <= 1'b0;
                done     <= 1'b1;
            end
        end
    end

    // R2: every new result is held for a second fast cycle
    p_hold_two_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (eval_vld && !$stable(pos_idx)) |=> $stable(pos_idx));

    // R3: consecutive results step the index down by one
    p_idx_desc_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (eval_vld && $past(eval_vld) && !$stable(pos_idx))
            |-> (pos_idx == $past(pos_idx) - IW'(1)));

    // R8: finished flag and result stream never overlap
    p_done_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && eval_vld));

    // R8: root count cannot exceed the number of positions
    p_count_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
        root_count <= CW'(N_POS));
endmodule

// File: tb/chien_eval_tb_top.sv
module chien_eval_tb_top;
    localparam int N    = 85;
    localparam int NSIG = 9;
    localparam int NOMG = 8;
    localparam int IW   = $clog2(N);
    localparam int CW   = $clog2(N + 1);

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic [NSIG*8-1:0] sig_coef = '0;
    logic [NOMG*8-1:0] omg_coef = '0;
    logic              eval_vld;
    logic [IW-1:0]     pos_idx;
    logic [7:0]        sig_val, sig_odd_val, omg_val;
    logic              root_flag, done;
    logic [CW-1:0]     root_count;

    int total = 0;
    int bad   = 0;

    logic [7:0] exp_t [255];
    int         log_t [256];
    logic [7:0] sig_a [NSIG];
    logic [7:0] omg_a [NOMG];

    always #5 clk = ~clk;

    chien_eval #(.N_POS(N), .NSIG(NSIG), .NOMG(NOMG)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start),
        .sig_coef(sig_coef), .omg_coef(omg_coef),
        .eval_vld(eval_vld), .pos_idx(pos_idx),
        .sig_val(sig_val), .sig_odd_val(sig_odd_val), .omg_val(omg_val),
        .root_flag(root_flag), .done(done), .root_count(root_count)
    );

    task automatic chk(input string req, input string what, input int act, input int expv);
        total++;
        if (act != expv) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, expv);
        end
    endtask

    function automatic logic [7:0] bm(input logic [7:0] a, input logic [7:0] b);
        if (a == 0 || b == 0) return 8'h00;
        return exp_t[(log_t[a] + log_t[b]) % 255];
    endfunction

    function automatic logic [7:0] a_neg(input int e);
        return exp_t[(255 - (e % 255)) % 255];
    endfunction

    function automatic logic [7:0] ref_sig(input int p, input bit odd_only);
        logic [7:0] acc = 8'h00;
        for (int j = 0; j < NSIG; j++)
            if (!odd_only || (j % 2 == 1)) acc = acc ^ bm(sig_a[j], a_neg(j * p));
        return acc;
    endfunction

    function automatic logic [7:0] ref_omg(input int p);
        logic [7:0] acc = 8'h00;
        for (int j = 0; j < NOMG; j++) acc = acc ^ bm(omg_a[j], a_neg(j * p));
        return acc;
    endfunction

    task automatic clear_sig();
        for (int j = 0; j < NSIG; j++) sig_a[j] = 8'h00;
        sig_a[0] = 8'h01;
    endtask

    // multiply the locator by (1 + alpha^p x): root at alpha^-p
    task automatic add_root(input int p);
        logic [7:0] x;
        x = exp_t[p % 255];
        for (int j = NSIG - 1; j >= 1; j--) sig_a[j] = sig_a[j] ^ bm(x, sig_a[j-1]);
    endtask

    task automatic seed_omg(input int seed);
        for (int j = 0; j < NOMG; j++) omg_a[j] = exp_t[(seed * 7 + j * 13) % 255];
    endtask

    task automatic run_scan(input string tag, input bit disturb);
        int         roots;
        int         p;
        logic [7:0] es, eo, ew;
        roots = 0;
        for (int j = 0; j < NSIG; j++) sig_coef[8*j +: 8] = sig_a[j];
        for (int j = 0; j < NOMG; j++) omg_coef[8*j +: 8] = omg_a[j];
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        chk("R8", {tag, " done cleared by start"}, done, 0);
        repeat (3) @(negedge clk);
        chk("R2", {tag, " no result after 3 edges"}, eval_vld, 0);
        @(negedge clk);
        for (int k = 0; k < N; k++) begin
            p  = N - 1 - k;
            es = ref_sig(p, 1'b0);
            eo = ref_sig(p, 1'b1);
            ew = ref_omg(p);
            if (es == 8'h00) roots++;
            chk("R2", {tag, " valid"}, eval_vld, 1);
            chk("R3", {tag, " index"}, pos_idx, p);
            chk((disturb && k > 10) ? "R10" : "R4", {tag, " locator"}, sig_val, es);
            chk("R5", {tag, " odd part"}, sig_odd_val, eo);
            chk((disturb && k > 10) ? "R10" : "R6", {tag, " evaluator"}, omg_val, ew);
            chk("R7", {tag, " root flag"}, root_flag, (es == 8'h00) ? 1 : 0);
            @(negedge clk);
            chk("R2", {tag, " hold index"}, pos_idx, p);
            chk("R2", {tag, " hold locator"}, sig_val, es);
            chk("R2", {tag, " hold valid"}, eval_vld, 1);
            if (k == N - 1) chk("R8", {tag, " done not early"}, done, 0);
            if (disturb && k == 10) begin
                start    = 1'b1;
                sig_coef = {NSIG{8'hA5}};
                omg_coef = {NOMG{8'h3C}};
            end
            @(negedge clk);
            if (disturb && k == 10) start = 1'b0;
        end
        chk("R8", {tag, " valid falls"}, eval_vld, 0);
        chk("R8", {tag, " done set"}, done, 1);
        chk(disturb ? "R9" : "R8", {tag, " root count"}, root_count, roots);
        repeat (3) @(negedge clk);
        chk("R8", {tag, " done holds"}, done, 1);
    endtask

    task automatic t_reset();
        chk("R1", "reset valid", eval_vld, 0);
        chk("R1", "reset done", done, 0);
        chk("R1", "reset count", root_count, 0);
        chk("R1", "reset index", pos_idx, 0);
        chk("R1", "reset locator", sig_val, 0);
        chk("R1", "reset odd", sig_odd_val, 0);
        chk("R1", "reset evaluator", omg_val, 0);
        chk("R1", "reset flag", root_flag, 0);
    endtask

    task automatic t_general();
        for (int j = 0; j < NSIG; j++) sig_a[j] = exp_t[(j * 31 + 5) % 255];
        seed_omg(3);
        run_scan("general", 1'b0);
    endtask

    task automatic t_edge_roots();
        clear_sig();
        add_root(0);
        add_root(N - 1);
        add_root(40);
        seed_omg(11);
        run_scan("edge roots", 1'b0);
        chk("R8", "edge roots exact count", root_count, 3);
    endtask

    task automatic t_full_degree();
        clear_sig();
        for (int r = 0; r < 8; r++) add_root(3 + r * 10);
        seed_omg(29);
        run_scan("full degree", 1'b0);
        chk("R8", "full degree exact count", root_count, 8);
    endtask

    task automatic t_all_zero();
        for (int j = 0; j < NSIG; j++) sig_a[j] = 8'h00;
        for (int j = 0; j < NOMG; j++) omg_a[j] = 8'h00;
        run_scan("zero locator", 1'b0);
        chk("R8", "zero locator count", root_count, N);
    endtask

    task automatic t_disturb();
        clear_sig();
        add_root(12);
        add_root(70);
        seed_omg(41);
        run_scan("busy start", 1'b1);
        chk("R9", "busy start count", root_count, 2);
    endtask

    initial begin
        exp_t[0] = 8'h01;
        for (int e = 1; e < 255; e++)
            exp_t[e] = {exp_t[e-1][6:0], 1'b0} ^ (exp_t[e-1][7] ? 8'h1D : 8'h00);
        log_t[0] = 0;
        for (int e = 0; e < 255; e++) log_t[exp_t[e]] = e;

        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_general();
        t_edge_roots();
        t_full_degree();
        t_all_zero();
        t_disturb();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(200000 * 10);
        total++;
        bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule